// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 48-bit virtual address into a physical address by reading a fixed four-level hierarchy of translation tables from memory. A client raises a request that carries the virtual address and a read/write flag. The walker takes the root table base from a root-pointer input and uses four 9-bit slices of the virtual address, from the most significant slice down. For each slice it reads one 64-bit entry through a single-outstanding read port. Each entry names the base of the next table. The last entry names the 4 KB page frame.

When the walk finishes, the block returns either a one-cycle completion pulse with the physical address, or a one-cycle fault pulse with a code. A walk fails with a not-present fault if any entry lacks its present bit. A write request fails with a protection fault if the final entry is not writable. Memory latency can be any number of cycles, and only one walk runs at a time.

Top module: `pt_walker`

## Requirements
- R1: In the cycle after synchronous reset, `busy`, `done`, `fault` and `mem_req` are all low.
- R2: A request is accepted only while `busy` is low. `busy` rises in the cycle after acceptance and falls in the same cycle that `done` or `fault` rises. A request raised while `busy` is high is ignored.
- R3: The read for level L (0 = top) goes to address base + index*8. The index is virtual address bits [47-9L : 39-9L]. For L=0 the base is `root_ptr` as sampled at acceptance. For L>0 the base is the frame field of the previous entry with 12 zero bits appended.
- R4: At most one read is outstanding. `mem_req` is a one-cycle pulse, and it is not raised again until `mem_rsp_valid` has returned the previous entry.
- R5: Entry format: bit 0 is present, bit 1 is writable, and bits [51:12] are the frame number. All other bits are ignored.
- R6: A successful walk makes exactly four reads. It then pulses `done` for one cycle, with `done_pa` = {leaf frame, virtual address bits [11:0]} and `fault_code` = 2'b00.
- R7: An entry with present = 0 at level L ends the walk with a one-cycle `fault` pulse and `fault_code` = 2'b01, after exactly L+1 reads and with no further read.
- R8: A write request whose leaf entry has writable = 0 ends with `fault` and `fault_code` = 2'b10, and no `done`. A read request to the same leaf completes normally.
- R9: A `mem_rsp_valid` pulse while the walker is idle has no effect on any output.
- R10: Each accepted request ends with exactly one of `done` or `fault`, and the two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request |
| req_va | input | 48 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read access |
| root_ptr | input | 52 | Physical base of the top-level table |
| busy | output | 1 | Walk in progress |
| mem_req | output | 1 | Entry read request pulse |
| mem_addr | output | 52 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 64 | Returned table entry |
| done | output | 1 | Translation complete pulse |
| done_pa | output | 52 | Translated physical address |
| fault | output | 1 | Walk failed pulse |
| fault_code | output | 2 | 01 not present, 10 write to read-only page, 00 none |

## Verification
The bench builds the tables for each case and checks every read address, so a design that sliced the wrong bits or forgot the ×8 scaling would read the wrong entry. The all-ones address is included because it exposes an index that overflows or truncates. Absent entries are placed at each of the four levels in turn. A design that kept reading after a clear present bit would show too many reads, and one that tested the bit only at the leaf would report the wrong code. Further cases cover a read-only leaf under both read and write, a second request held high while busy, and a stray response while idle. These catch a walker that restarts mid-walk or that acts on unsolicited data.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int VA_W    = 48;
  localparam int PA_W    = 52;
  localparam int ENT_W   = 64;
  localparam int IDX_W   = 9;
  localparam int OFF_W   = 12;
  localparam int LVL_N   = 4;
  localparam int PRES_B  = 0;
  localparam int WR_B    = 1;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'b00,
    FLT_ABSENT = 2'b01,
    FLT_PROT   = 2'b10
  } flt_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } st_e;
endpackage

// File: rtl/ptw_index_sel.sv
module ptw_index_sel #(
  parameter int VA_W  = 48,
  parameter int PA_W  = 52,
  parameter int ENT_W = 64,
  parameter int IDX_W = 9,
  parameter int OFF_W = 12,
  parameter int LVL_N = 4,
  localparam int LVL_W = $clog2(LVL_N),
  localparam int SH    = $clog2(ENT_W / 8)
) (
  input  logic [VA_W-1:0]  va,
  input  logic [LVL_W-1:0] lvl,
  input  logic [PA_W-1:0]  base,
  output logic [PA_W-1:0]  ent_addr
);
  logic [IDX_W-1:0] slice [LVL_N];

  // level 0 takes the top slice, the last level the slice just above the offset
  for (genvar g = 0; g < LVL_N; g++) begin : g_slice
    assign slice[g] = va[OFF_W + IDX_W*(LVL_N-g) - 1 -: IDX_W];
  end

  logic unused_va;
  assign unused_va = ^va[OFF_W-1:0];

  assign ent_addr = base + (PA_W'(slice[lvl]) << SH);
endmodule

// File: rtl/ptw_entry_decode.sv
module ptw_entry_decode #(
  parameter int PA_W   = 52,
  parameter int ENT_W  = 64,
  parameter int OFF_W  = 12,
  parameter int PRES_B = 0,
  parameter int WR_B   = 1
) (
  input  logic [ENT_W-1:0] ent,
  output logic             present,
  output logic             writable,
  output logic [PA_W-1:0]  next_base
);
  assign present   = ent[PRES_B];
  assign writable  = ent[WR_B];
  assign next_base = {ent[PA_W-1:OFF_W], {OFF_W{1'b0}}};

  logic unused_bits;
  assign unused_bits = ^{ent[ENT_W-1:PA_W], ent[OFF_W-1:2]};
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int VA_W  = ptw_pkg::VA_W,
  parameter int PA_W  = ptw_pkg::PA_W,
  parameter int ENT_W = ptw_pkg::ENT_W,
  parameter int IDX_W = ptw_pkg::IDX_W,
  parameter int OFF_W = ptw_pkg::OFF_W,
  parameter int LVL_N = ptw_pkg::LVL_N,
  localparam int LVL_W = $clog2(LVL_N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_va,
  input  logic             req_write,
  input  logic [PA_W-1:0]  root_ptr,
  output logic             busy,
  output logic             mem_req,
  output logic [PA_W-1:0]  mem_addr,
  input  logic             mem_rsp_valid,
  input  logic [ENT_W-1:0] mem_rsp_data,
  output logic             done,
  output logic [PA_W-1:0]  done_pa,
  output logic             fault,
  output logic [1:0]       fault_code
);
  st_e              state;
  logic [LVL_W-1:0] lvl;
  logic [VA_W-1:0]  va_q;
  logic             wr_q;

  logic             e_present, e_writable;
  logic [PA_W-1:0]  e_base;
  logic [VA_W-1:0]  sel_va;
  logic [LVL_W-1:0] sel_lvl;
  logic [PA_W-1:0]  sel_base;
  logic [PA_W-1:0]  ent_addr;
  logic             last_lvl;

  ptw_entry_decode #(
    .PA_W(PA_W), .ENT_W(ENT_W), .OFF_W(OFF_W), .PRES_B(PRES_B), .WR_B(WR_B)
  ) u_dec (
    .ent(mem_rsp_data), .present(e_present), .writable(e_writable), .next_base(e_base)
  );

  // one address generator: first level from the request, later levels from the entry
  always_comb begin
    if (state == ST_IDLE) begin
      sel_va   = req_va;
      sel_lvl  = '0;
      sel_base = root_ptr;
    end else begin
      sel_va   = va_q;
      sel_lvl  = lvl + LVL_W'(1);
      sel_base = e_base;
    end
  end

  ptw_index_sel #(
    .VA_W(VA_W), .PA_W(PA_W), .ENT_W(ENT_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .LVL_N(LVL_N)
  ) u_idx (
    .va(sel_va), .lvl(sel_lvl), .base(sel_base), .ent_addr(ent_addr)
  );

  assign last_lvl = (lvl == LVL_W'(LVL_N - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      lvl        <= '0;
      va_q       <= '0;
      wr_q       <= 1'b0;
      busy       <= 1'b0;
      mem_req    <= 1'b0;
      mem_addr   <= '0;
      done       <= 1'b0;
      done_pa    <= '0;
      fault      <= 1'b0;
      fault_code <= FLT_NONE;
    end else begin
      mem_req <= 1'b0;
      done    <= 1'b0;
      fault   <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            va_q     <= req_va;
            wr_q     <= req_write;
            lvl      <= '0;
            mem_req  <= 1'b1;
            mem_addr <= ent_addr;
            busy     <= 1'b1;
            state    <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            if (!e_present) begin
              fault      <= 1'b1;
              fault_code <= FLT_ABSENT;
              busy       <= 1'b0;
              state      <= ST_IDLE;
            end else if (last_lvl) begin
              busy  <= 1'b0;
              state <= ST_IDLE;
              if (wr_q && !e_writable) begin
                fault      <= 1'b1;
                fault_code <= FLT_PROT;
              end else begin
                done       <= 1'b1;
                fault_code <= FLT_NONE;
                done_pa    <= {e_base[PA_W-1:OFF_W], va_q[OFF_W-1:0]};
              end
            end else begin
              lvl      <= lvl + LVL_W'(1);
              mem_req  <= 1'b1;
              mem_addr <= ent_addr;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int VA_W = 48,
  parameter int PA_W = 52,
  parameter int OFF_W = 12
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic [VA_W-1:0] req_va,
  input logic            busy,
  input logic            mem_req,
  input logic            mem_rsp_valid,
  input logic            done,
  input logic [PA_W-1:0] done_pa,
  input logic            fault
);
  logic            outst;
  logic [VA_W-1:0] va_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      outst <= 1'b0;
      va_c  <= '0;
    end else begin
      if (mem_req) outst <= 1'b1;
      else if (mem_rsp_valid) outst <= 1'b0;
      if (!busy && req_valid) va_c <= req_va;
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> (!busy && !done && !fault && !mem_req));

  // R2
  accept_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && req_valid) |=> busy);

  // R2
  busy_end_chk: assert property (@(posedge clk) disable iff (rst)
    (done || fault) |-> (!busy && $past(busy)));

  // R4
  single_read_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !outst);

  // R6
  offset_pass_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (done_pa[OFF_W-1:0] == va_c[OFF_W-1:0]));

  // R10
  one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
    !(done && fault));
endmodule

bind pt_walker pt_walker_chk #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_va(req_va), .busy(busy),
  .mem_req(mem_req), .mem_rsp_valid(mem_rsp_valid), .done(done),
  .done_pa(done_pa), .fault(fault)
);

// File: tb/pt_walker_bench.sv
`timescale 1ns/1ps
module pt_walker_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [47:0] req_va = '0;
  logic        req_write = 1'b0;
  logic [51:0] root_ptr = 52'h5 << 44;
  logic        busy, mem_req, done, fault;
  logic [51:0] mem_addr, done_pa;
  logic [1:0]  fault_code;
  logic        model_v = 1'b0, stray_v = 1'b0;
  logic [63:0] model_d = '0, stray_d = '0;
  logic        mem_rsp_valid;
  logic [63:0] mem_rsp_data;

  assign mem_rsp_valid = model_v | stray_v;
  assign mem_rsp_data  = stray_v ? stray_d : model_d;

  always #4 clk = ~clk;

  pt_walker u_pt_walker (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_va(req_va), .req_write(req_write),
    .root_ptr(root_ptr), .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .done(done),
    .done_pa(done_pa), .fault(fault), .fault_code(fault_code)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory model
  logic [63:0] pmem [logic [51:0]];
  logic [51:0] rd_log [16];
  int          rd_n = 0;
  int          lat = 0;
  bit          pend = 0;
  int          wcnt = 0;
  logic [51:0] paddr;

  always @(posedge clk) begin
    model_v <= 1'b0;
    if (mem_req) begin
      pend  <= 1'b1;
      paddr <= mem_addr;
      wcnt  <= lat;
      if (rd_n < 16) rd_log[rd_n] <= mem_addr;
      rd_n  <= rd_n + 1;
    end else if (pend) begin
      if (wcnt == 0) begin
        model_v <= 1'b1;
        model_d <= pmem.exists(paddr) ? pmem[paddr] : 64'h0;
        pend    <= 1'b0;
      end else wcnt <= wcnt - 1;
    end
  end

  function automatic logic [51:0] tbl_base(input int l, input logic [47:0] va);
    if (l == 0) return root_ptr;
    return (52'(l) << 40) | (52'(va >> (48 - 9*l)) << 12);
  endfunction

  function automatic logic [51:0] ent_at(input int l, input logic [47:0] va);
    logic [51:0] idx = 52'((va >> (12 + 9*(3-l))) & 48'h1FF);
    return tbl_base(l, va) + (idx << 3);
  endfunction

  function automatic logic [39:0] leaf_frame(input logic [47:0] va);
    return 40'h90_0000_0000 | (40'(va[47:12]) ^ 40'h00_0F0F_0F0F);
  endfunction

  // kind: 0 writable leaf, 1 read-only leaf, 2 absent at level ablvl
  task automatic build(input logic [47:0] va, input int kind, input int ablvl);
    pmem.delete();
    for (int l = 0; l < 4; l++) begin
      if (kind == 2 && l == ablvl) begin
        pmem[ent_at(l, va)] = 64'hFFFF_FFFF_FFFF_FFFE; // present clear, other bits set
        break;
      end
      if (l < 3) pmem[ent_at(l, va)] = {12'hABC, tbl_base(l+1, va)[51:12], 10'h2A8, 2'b11};
      else       pmem[ent_at(l, va)] = {12'h0, leaf_frame(va), 10'h155, (kind == 0), 1'b1};
    end
  endtask

  task automatic wait_end(output bit got);
    got = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (done || fault) begin got = 1; break; end
    end
  endtask

  task automatic run_walk(input logic [47:0] va, input bit wr, input int kind, input int ablvl, input int l_lat);
    bit got;
    int exp_n;
    lat = l_lat;
    build(va, kind, ablvl);
    @(negedge clk);
    rd_n = 0;
    req_valid = 1'b1; req_va = va; req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy === 1'b1, "R2 busy after accept", 64'(busy), 64'h1);
    wait_end(got);
    chk(got, "R10 walk ended", 64'(got), 64'h1);
    exp_n = (kind == 2) ? ablvl + 1 : 4;
    chk(rd_n == exp_n, (kind == 2) ? "R7 read count" : "R6 read count", 64'(rd_n), 64'(exp_n));
    for (int l = 0; l < exp_n && l < rd_n; l++)
      chk(rd_log[l] == ent_at(l, va), "R3 entry address", 64'(rd_log[l]), 64'(ent_at(l, va)));
    chk(busy === 1'b0, "R2 busy low at end", 64'(busy), 64'h0);
    if (kind == 2) begin
      chk(fault && !done && fault_code == 2'b01, "R7 absent fault", {fault, done, fault_code}, 64'b1001);
    end else if (kind == 1 && wr) begin
      chk(fault && !done && fault_code == 2'b10, "R8 protection fault", {fault, done, fault_code}, 64'b1010);
    end else begin
      chk(done && !fault && fault_code == 2'b00, "R6 done", {fault, done, fault_code}, 64'b0100);
      chk(done_pa == {leaf_frame(va), va[11:0]}, "R5 R6 physical address", 64'(done_pa),
          64'({leaf_frame(va), va[11:0]}));
    end
    @(negedge clk);
    chk(!done && !fault, "R10 single pulse", {done, fault}, 64'h0);
    repeat (3) @(negedge clk);
    chk(rd_n == exp_n, "R7 no reads after end", 64'(rd_n), 64'(exp_n));
  endtask

  typedef struct packed {
    logic [47:0] va;
    logic        wr;
    logic [1:0]  kind;
    logic [1:0]  ablvl;
    logic [2:0]  lat;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{48'h0000_0000_0000, 1'b0, 2'd0, 2'd0, 3'd0},
    '{48'hFFFF_FFFF_FFFF, 1'b1, 2'd0, 2'd0, 3'd3},
    '{48'h1234_5678_9ABC, 1'b0, 2'd1, 2'd0, 3'd1},
    '{48'h2345_6789_ABCD, 1'b1, 2'd1, 2'd0, 3'd2},
    '{48'h4000_0000_0123, 1'b1, 2'd2, 2'd0, 3'd2},
    '{48'h8000_4000_0456, 1'b0, 2'd2, 2'd1, 3'd0},
    '{48'hC0DE_0020_0789, 1'b0, 2'd2, 2'd2, 3'd5},
    '{48'h7FFF_FFE0_1FFF, 1'b1, 2'd2, 2'd3, 3'd1},
    '{48'h0AB0_CDEF_0001, 1'b1, 2'd0, 2'd0, 3'd7}
  };

  initial begin
    int cyc = 0;
    while (!finished && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    bit got;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !fault && !mem_req, "R1 reset state", {busy, done, fault, mem_req}, 64'h0);

    foreach (VECS[i])
      run_walk(VECS[i].va, VECS[i].wr, int'(VECS[i].kind), int'(VECS[i].ablvl), int'(VECS[i].lat));

    // R2: request held high while busy is ignored
    lat = 4;
    build(48'h1111_2222_3333, 0, 0);
    @(negedge clk);
    rd_n = 0;
    req_valid = 1'b1; req_va = 48'h1111_2222_3333; req_write = 1'b0;
    @(negedge clk);
    req_va = 48'h6666_7777_8888;
    wait_end(got);
    req_valid = 1'b0;
    chk(done && done_pa == {leaf_frame(48'h1111_2222_3333), 12'h333}, "R2 busy request ignored",
        64'(done_pa), 64'({leaf_frame(48'h1111_2222_3333), 12'h333}));
    chk(rd_n == 4, "R2 no restart", 64'(rd_n), 64'h4);
    @(negedge clk);
    chk(!busy, "R2 idle after held request", 64'(busy), 64'h0);

    // R9: stray response while idle
    repeat (2) @(negedge clk);
    rd_n = 0;
    stray_d = 64'h0000_0000_0000_1003;
    stray_v = 1'b1;
    @(negedge clk);
    stray_v = 1'b0;
    for (int k = 0; k < 4; k++) begin
      chk(!done && !fault && !busy && !mem_req, "R9 stray response ignored",
          {done, fault, busy, mem_req}, 64'h0);
      @(negedge clk);
    end
    chk(rd_n == 0, "R9 no read from stray", 64'(rd_n), 64'h0);

    // R1: reset in the middle of a walk
    lat = 6;
    build(48'h3333_0000_0042, 0, 0);
    req_valid = 1'b1; req_va = 48'h3333_0000_0042; req_write = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(!busy && !done && !fault && !mem_req, "R1 reset mid-walk", {busy, done, fault, mem_req}, 64'h0);
    repeat (10) @(negedge clk);
    chk(!done && !fault, "R9 late response after reset ignored", {done, fault}, 64'h0);

    run_walk(48'h5555_AAAA_5555, 1'b1, 0, 0, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule